// File: doc/BRIEF.md
# Two-Port Memory with Cross-Port Mailbox Interrupts

This block is a synchronous two-port static memory. It has two fully independent access ports, called A and B, on one clock. Each port can read or write any word of a shared array. The array depth (as address width) and the word width are parameters.

The two highest addresses also act as mailboxes between the ports:

- The all-ones address is the mailbox of port B. A write there from port A raises B's interrupt.
- The all-ones-minus-one address is the mailbox of port A. A write there from port B raises A's interrupt.
- The receiving port clears its own interrupt by reading its own mailbox.

Each mailbox word still holds data, so the sender can leave a message that the receiver collects with the same read that clears the interrupt.

Each port has a busy input. While a port's busy input is active (low), that port's accesses leave both interrupt flags unchanged, but the data transfer still takes place. Software on either side can therefore use the same protocol with the roles swapped.

Top module: `dpm_mailbox_top`

## Requirements
- R1: While reset is high, and on the first sample after it falls, both interrupt outputs are high (inactive) and both read-data outputs are zero.
- R2: A read access returns the stored word on that port's read-data output after the same clock edge that samples it. A read access is chip enable low, write select high and output enable low. A word written by either port can be read back from either port.
- R3: A write by port A to the all-ones address, with A's busy input high, drives B's interrupt output low after that edge. A's interrupt output does not change.
- R4: A read by port B of the all-ones address, with B's busy input high, returns B's interrupt output high after that edge.
- R5: The same pair exists in the other direction. A write by port B to the all-ones-minus-one address sets A's interrupt low. A read by port A of that address sets it high again.
- R6: When the accessing port's busy input is low, the access does not change any interrupt flag. Its data write or read still takes effect.
- R7: If, in one cycle, a set and a clear for the same interrupt flag are both sampled, the flag ends up set (low).
- R8: Both mailbox addresses store and return data words like any other address.
- R9: Accesses that are not the defined set or clear leave both flags unchanged. These include:
  - a read of the peer's mailbox
  - a write to the port's own mailbox
  - an access with chip enable high
  - a read with output enable high
- R10: When a port makes no read access, its read-data output holds its last value.
- R11: Both ports operate in the same cycle without interfering. Simultaneous sets in both directions take effect together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_sel_n | input | 1 | Port A chip enable, active low |
| a_wr_n | input | 1 | Port A write select: low = write, high = read |
| a_oe_n | input | 1 | Port A output enable, active low, needed for reads |
| a_busy_n | input | 1 | Port A busy, active low; blocks flag changes from A's accesses |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A registered read data |
| a_irq_n | output | 1 | Port A interrupt, active low, registered |
| b_sel_n | input | 1 | Port B chip enable, active low |
| b_wr_n | input | 1 | Port B write select: low = write, high = read |
| b_oe_n | input | 1 | Port B output enable, active low, needed for reads |
| b_busy_n | input | 1 | Port B busy, active low; blocks flag changes from B's accesses |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B registered read data |
| b_irq_n | output | 1 | Port B interrupt, active low, registered |

## Verification
Every result of this block appears after exactly one rising edge: the read-data word and the interrupt output both come from registers loaded by the edge that samples the access. The bench drives each access on a falling edge and checks the outputs at the next falling edge. That sample is the first one after the edge that loads the registers. The bench drops the access before that sample, so the following edge shows whether the flag and data hold. Clears, blocked accesses and collisions of a set with a clear are checked one cycle after the access, against the state the flag held before.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

  localparam int NUM_PORTS = 2;

  // Decoded view of one port's access in the current cycle
  typedef struct packed {
    logic wr;        // valid write access
    logic rd;        // valid read access
    logic hit_own;   // address is this port's own mailbox
    logic hit_peer;  // address is the opposite port's mailbox
    logic flag_ok;   // busy not active: flag changes allowed
  } acc_t;

endpackage

// File: rtl/dpm_port_dec.sv
module dpm_port_dec
  import dpm_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] OWN_BOX  = '1,
  parameter logic [ADDR_W-1:0] PEER_BOX = '0
) (
  input  logic              sel_n,
  input  logic              wr_n,
  input  logic              oe_n,
  input  logic              busy_n,
  input  logic [ADDR_W-1:0] addr,
  output acc_t              acc
);

  always_comb begin
    acc          = '0;
    acc.wr       = !sel_n && !wr_n;
    acc.rd       = !sel_n && wr_n && !oe_n;
    acc.hit_own  = (addr == OWN_BOX);
    acc.hit_peer = (addr == PEER_BOX);
    acc.flag_ok  = busy_n;
  end

endmodule

// File: rtl/dpm_tdp_ram.sv
module dpm_tdp_ram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_we,
  input  logic              a_re,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_we,
  input  logic              b_re,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Writes: port B is applied last on a same-address collision
  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    if (b_we) mem[b_addr] <= b_wdata;
  end

  // Registered read ports with synchronous reset of the output register
  always_ff @(posedge clk) begin
    if (rst) begin
      a_rdata <= '0;
    end else if (a_re) begin
      a_rdata <= mem[a_addr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      b_rdata <= '0;
    end else if (b_re) begin
      b_rdata <= mem[b_addr];
    end
  end

  AST_A_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !a_re |=> $stable(a_rdata)); // R10
  AST_B_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !b_re |=> $stable(b_rdata)); // R10

endmodule

// File: rtl/dpm_irq_flag.sv
module dpm_irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_n
);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_n <= 1'b1;
    end else if (set_i) begin
      irq_n <= 1'b0;
    end else if (clr_i) begin
      irq_n <= 1'b1;
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    set_i |=> !irq_n); // R7
  AST_CLEAR_RAISES: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> irq_n); // R4
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !set_i) |=> $stable(irq_n)); // R9

endmodule

// File: rtl/dpm_mailbox_top.sv
module dpm_mailbox_top
  import dpm_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_sel_n,
  input  logic              a_wr_n,
  input  logic              a_oe_n,
  input  logic              a_busy_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_irq_n,
  input  logic              b_sel_n,
  input  logic              b_wr_n,
  input  logic              b_oe_n,
  input  logic              b_busy_n,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_irq_n
);

  // Mailbox of port B is the top word, mailbox of port A the one below
  localparam logic [ADDR_W-1:0] BOX_B = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] BOX_A = {{(ADDR_W-1){1'b1}}, 1'b0};

  logic [NUM_PORTS-1:0] sel_n_v, wr_n_v, oe_n_v, busy_n_v;
  logic [ADDR_W-1:0]    addr_v [NUM_PORTS];
  acc_t                 acc_v  [NUM_PORTS];
  logic [NUM_PORTS-1:0] set_v, clr_v, irq_n_v;

  assign sel_n_v  = {b_sel_n,  a_sel_n};
  assign wr_n_v   = {b_wr_n,   a_wr_n};
  assign oe_n_v   = {b_oe_n,   a_oe_n};
  assign busy_n_v = {b_busy_n, a_busy_n};
  assign addr_v[0] = a_addr;
  assign addr_v[1] = b_addr;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam logic [ADDR_W-1:0] OWN  = (p == 0) ? BOX_A : BOX_B;
    localparam logic [ADDR_W-1:0] PEER = (p == 0) ? BOX_B : BOX_A;
    localparam int                OTHER = NUM_PORTS - 1 - p;

    dpm_port_dec #(
      .ADDR_W  (ADDR_W),
      .OWN_BOX (OWN),
      .PEER_BOX(PEER)
    ) u_dec (
      .sel_n (sel_n_v[p]),
      .wr_n  (wr_n_v[p]),
      .oe_n  (oe_n_v[p]),
      .busy_n(busy_n_v[p]),
      .addr  (addr_v[p]),
      .acc   (acc_v[p])
    );

    // Set comes from the opposite port writing this port's mailbox
    assign set_v[p] = acc_v[OTHER].wr && acc_v[OTHER].hit_peer && acc_v[OTHER].flag_ok;
    // Clear comes from this port reading its own mailbox
    assign clr_v[p] = acc_v[p].rd && acc_v[p].hit_own && acc_v[p].flag_ok;

    dpm_irq_flag u_flag (
      .clk  (clk),
      .rst  (rst),
      .set_i(set_v[p]),
      .clr_i(clr_v[p]),
      .irq_n(irq_n_v[p])
    );
  end

  assign a_irq_n = irq_n_v[0];
  assign b_irq_n = irq_n_v[1];

  dpm_tdp_ram #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_ram (
    .clk    (clk),
    .rst    (rst),
    .a_we   (acc_v[0].wr),
    .a_re   (acc_v[0].rd),
    .a_addr (a_addr),
    .a_wdata(a_wdata),
    .a_rdata(a_rdata),
    .b_we   (acc_v[1].wr),
    .b_re   (acc_v[1].rd),
    .b_addr (b_addr),
    .b_wdata(b_wdata),
    .b_rdata(b_rdata)
  );

  // Port-level checks of the mailbox protocol
  AST_A_SENDS_TO_B: assert property (@(posedge clk) disable iff (rst)
    (!a_sel_n && !a_wr_n && a_busy_n && a_addr == BOX_B) |=> !b_irq_n); // R3
  AST_B_SENDS_TO_A: assert property (@(posedge clk) disable iff (rst)
    (!b_sel_n && !b_wr_n && b_busy_n && b_addr == BOX_A) |=> !a_irq_n); // R5
  AST_BUSY_NO_SET_B: assert property (@(posedge clk) disable iff (rst)
    (b_irq_n && !a_busy_n && b_busy_n) |=> b_irq_n); // R6
  AST_BUSY_NO_SET_A: assert property (@(posedge clk) disable iff (rst)
    (a_irq_n && !b_busy_n && a_busy_n) |=> a_irq_n); // R6
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (a_irq_n && b_irq_n && a_rdata == '0 && b_rdata == '0)); // R1

endmodule

// File: tb/sim_dpm_mailbox_top.sv
`timescale 1ns/1ps
module sim_dpm_mailbox_top;

  localparam int AW = 10;
  localparam int DW = 18;
  localparam logic [AW-1:0] TOP  = {AW{1'b1}};
  localparam logic [AW-1:0] TOP1 = {{(AW-1){1'b1}}, 1'b0};

  logic clk = 1'b0;
  logic rst;
  logic a_sel_n, a_wr_n, a_oe_n, a_busy_n;
  logic [AW-1:0] a_addr;
  logic [DW-1:0] a_wdata, a_rdata;
  logic a_irq_n;
  logic b_sel_n, b_wr_n, b_oe_n, b_busy_n;
  logic [AW-1:0] b_addr;
  logic [DW-1:0] b_wdata, b_rdata;
  logic b_irq_n;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dpm_mailbox_top #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst),
    .a_sel_n(a_sel_n), .a_wr_n(a_wr_n), .a_oe_n(a_oe_n), .a_busy_n(a_busy_n),
    .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata), .a_irq_n(a_irq_n),
    .b_sel_n(b_sel_n), .b_wr_n(b_wr_n), .b_oe_n(b_oe_n), .b_busy_n(b_busy_n),
    .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata), .b_irq_n(b_irq_n)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle_a();
    a_sel_n = 1; a_wr_n = 1; a_oe_n = 1; a_busy_n = 1;
  endtask
  task automatic idle_b();
    b_sel_n = 1; b_wr_n = 1; b_oe_n = 1; b_busy_n = 1;
  endtask

  task automatic wr_a(input logic [AW-1:0] ad, input logic [DW-1:0] d, input logic busy_n);
    a_sel_n = 0; a_wr_n = 0; a_oe_n = 1; a_busy_n = busy_n; a_addr = ad; a_wdata = d;
  endtask
  task automatic rd_a(input logic [AW-1:0] ad, input logic busy_n);
    a_sel_n = 0; a_wr_n = 1; a_oe_n = 0; a_busy_n = busy_n; a_addr = ad;
  endtask
  task automatic wr_b(input logic [AW-1:0] ad, input logic [DW-1:0] d, input logic busy_n);
    b_sel_n = 0; b_wr_n = 0; b_oe_n = 1; b_busy_n = busy_n; b_addr = ad; b_wdata = d;
  endtask
  task automatic rd_b(input logic [AW-1:0] ad, input logic busy_n);
    b_sel_n = 0; b_wr_n = 1; b_oe_n = 0; b_busy_n = busy_n; b_addr = ad;
  endtask

  task automatic t_reset();
    check("R1", "a_irq_n", a_irq_n, 1);
    check("R1", "b_irq_n", b_irq_n, 1);
    check("R1", "a_rdata", a_rdata, 0);
    check("R1", "b_rdata", b_rdata, 0);
  endtask

  task automatic t_data();
    for (int i = 0; i < 4; i++) begin
      wr_a(AW'(i * 37 + 5), DW'(18'h2A5A5 ^ (i * 18'h111)), 1);
      wr_b(AW'(i * 37 + 6), DW'(18'h15A5A + i), 1);
      step();
    end
    idle_a(); idle_b();
    for (int i = 0; i < 4; i++) begin
      rd_b(AW'(i * 37 + 5), 1);
      rd_a(AW'(i * 37 + 6), 1);
      step();
      check("R2", "b reads A word", b_rdata, DW'(18'h2A5A5 ^ (i * 18'h111)));
      check("R11", "a reads B word", a_rdata, DW'(18'h15A5A + i));
    end
    idle_a(); idle_b();
    step();
    check("R10", "a_rdata holds", a_rdata, DW'(18'h15A5A + 3));
    check("R10", "b_rdata holds", b_rdata, DW'(18'h2A5A5 ^ (3 * 18'h111)));
    check("R9", "no flags from data traffic", {a_irq_n, b_irq_n}, 2'b11);
  endtask

  task automatic t_a_to_b();
    wr_a(TOP, 18'h3C3C3, 1);
    step();
    check("R3", "b_irq_n set", b_irq_n, 0);
    check("R3", "a_irq_n untouched", a_irq_n, 1);
    idle_a();
    rd_a(TOP, 1);
    step();
    check("R8", "a reads B mailbox", a_rdata, 18'h3C3C3);
    check("R9", "peer read keeps b flag", b_irq_n, 0);
    idle_a();
    rd_b(TOP, 1);
    step();
    check("R8", "b reads own mailbox", b_rdata, 18'h3C3C3);
    check("R4", "b_irq_n cleared", b_irq_n, 1);
    idle_b();
    step();
    check("R4", "b_irq_n stays clear", b_irq_n, 1);
  endtask

  task automatic t_b_to_a();
    wr_b(TOP1, 18'h0F0F1, 1);
    step();
    check("R5", "a_irq_n set", a_irq_n, 0);
    check("R5", "b_irq_n untouched", b_irq_n, 1);
    idle_b();
    step();
    check("R5", "a_irq_n held", a_irq_n, 0);
    rd_a(TOP1, 1);
    step();
    check("R8", "a reads own mailbox", a_rdata, 18'h0F0F1);
    check("R5", "a_irq_n cleared", a_irq_n, 1);
    idle_a();
  endtask

  task automatic t_busy();
    wr_a(TOP, 18'h11111, 0);
    step();
    idle_a();
    check("R6", "busy A write no set", b_irq_n, 1);
    rd_b(TOP, 1);
    step();
    idle_b();
    check("R6", "busy write still stored", b_rdata, 18'h11111);
    wr_a(TOP, 18'h22222, 1);
    step();
    idle_a();
    check("R3", "set before busy clear", b_irq_n, 0);
    rd_b(TOP, 0);
    step();
    idle_b();
    check("R6", "busy B read no clear", b_irq_n, 0);
    check("R6", "busy read returns data", b_rdata, 18'h22222);
    rd_b(TOP, 1);
    step();
    idle_b();
    check("R4", "clear after busy", b_irq_n, 1);
  endtask

  task automatic t_ignored();
    wr_a(TOP1, 18'h00007, 1);
    step();
    idle_a();
    check("R9", "A write own box", {a_irq_n, b_irq_n}, 2'b11);
    wr_b(TOP, 18'h00008, 1);
    step();
    idle_b();
    check("R9", "B write own box", {a_irq_n, b_irq_n}, 2'b11);
    a_sel_n = 1; a_wr_n = 0; a_addr = TOP; a_wdata = 18'h3FFFF; a_busy_n = 1;
    step();
    idle_a();
    check("R9", "deselected write", b_irq_n, 1);
    wr_a(TOP, 18'h00009, 1);
    step();
    idle_a();
    b_sel_n = 0; b_wr_n = 1; b_oe_n = 1; b_addr = TOP; b_busy_n = 1;
    step();
    idle_b();
    check("R9", "read without oe keeps flag", b_irq_n, 0);
    rd_b(TOP, 1);
    step();
    idle_b();
    check("R4", "cleanup clear", b_irq_n, 1);
  endtask

  task automatic t_priority();
    // Flag clear before: set and clear meet
    wr_a(TOP, 18'h00AAA, 1);
    rd_b(TOP, 1);
    step();
    check("R7", "set wins from clear", b_irq_n, 0);
    // Flag already set: set and clear meet again
    step();
    idle_a(); idle_b();
    check("R7", "set wins from set", b_irq_n, 0);
    rd_b(TOP, 1);
    step();
    idle_b();
    check("R4", "clear after collision", b_irq_n, 1);
  endtask

  task automatic t_both();
    wr_a(TOP, 18'h12345, 1);
    wr_b(TOP1, 18'h2BCDE, 1);
    step();
    idle_a(); idle_b();
    check("R11", "both flags set", {a_irq_n, b_irq_n}, 2'b00);
    rd_a(TOP1, 1);
    rd_b(TOP, 1);
    step();
    idle_a(); idle_b();
    check("R11", "both flags clear", {a_irq_n, b_irq_n}, 2'b11);
    check("R8", "a box data", a_rdata, 18'h2BCDE);
    check("R8", "b box data", b_rdata, 18'h12345);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1;
    idle_a(); idle_b();
    a_addr = '0; b_addr = '0; a_wdata = '0; b_wdata = '0;
    repeat (3) step();
    check("R1", "irq in reset", {a_irq_n, b_irq_n}, 2'b11);
    rst = 0;
    step();
    t_reset();
    t_data();
    t_a_to_b();
    t_b_to_a();
    t_busy();
    t_ignored();
    t_priority();
    t_both();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule